// File: doc/BRIEF.md
# Exponent-Timed GPIO Debounce Filter

This block cleans up one general-purpose input pin before the rest of the chip sees it. The raw pin is first brought into the clock domain through a short flop chain. A change of level then reaches the filtered output only after the synchronised input has stayed at its new value for a programmed number of millisecond ticks. The tick is a single-cycle strobe shared by many pins and generated elsewhere.

The period is not given as a cycle count. It comes from a 3-bit exponent `n` in the control word and equals 2^n ticks, so the choices run from 1 ms to 128 ms. A separate enable bit in the same word switches filtering on. While that bit is clear the filter is bypassed and the output follows the synchronised input one clock later. Any change of the enable or the exponent throws away the partial count. The block has no data stream, so every pin is a plain control or status level.

Top module: `gpio_debounce_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `filt_out` equals the parameter `RST_LEVEL` (default 0), whatever `raw_in` does, and the stability count is zero.
- R2: With the enable bit (`ctrl_word[8]`) clear, `filt_out` takes the value of `raw_in` three clock edges after `raw_in` changes (two synchroniser stages plus one output register), and no tick is needed.
- R3: With the enable bit set and exponent `n = ctrl_word[7:5]`, a change of the synchronised input reaches `filt_out` on the clock edge of the 2^n-th `ms_tick` counted while the input differs from `filt_out`, and not before.
- R4: If the synchronised input returns to the current `filt_out` value before the period ends, the count restarts from zero and `filt_out` is unchanged.
- R5: Only cycles with `ms_tick` high advance the count; with filtering enabled and no ticks, `filt_out` never changes.
- R6: A change of the enable bit or of the exponent restarts the count at zero. A tick that arrives in the same cycle as such a change is not counted.
- R7: Bits 4:0 of `ctrl_word` are ignored: they neither alter the period nor restart the count.
- R8: The stability count stays below the decoded period 2^n whenever no restart is being applied.
- R9: The exponent limits work at both ends: `n = 0` needs one tick and `n = 7` needs exactly 128 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe, shared |
| ctrl_word | input | 9 | Control word: bit 8 enables filtering, bits 7:5 hold the exponent n, bits 4:0 unused |
| raw_in | input | 1 | Asynchronous raw pin level |
| filt_out | output | 1 | Debounced (or bypassed) pin level |

## Verification
Two events can fall in the same cycle: a millisecond tick and a reprogramming of the exponent. When both occur, the restart must win and the tick must be lost. The bench sets up a partial count under a 2-tick period. It then raises `ms_tick` in the very cycle that changes the exponent to zero, so the terminal count would be reached at once if the tick were counted. The output must hold its old level after that cycle and switch only on the next tick.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  // Control word layout.
  localparam int CTRL_W  = 9;
  localparam int EN_BIT  = 8;
  localparam int EXP_LSB = 5;
  localparam int EXP_W   = 3;
  // Longest period is 2**(2**EXP_W - 1) ticks; the limit needs one more bit.
  localparam int LIM_W   = 1 << EXP_W;

  typedef struct packed {
    logic             en;
    logic [EXP_W-1:0] expo;
  } dbcfg_t;
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
  parameter int   STAGES    = 2,
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= RST_LEVEL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= RST_LEVEL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gdb_period_decode.sv
module gdb_period_decode
  import gdb_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_word,
  output dbcfg_t            cfg,
  output logic [LIM_W-1:0]  limit
);
  logic [EXP_LSB-1:0] unused_ctrl_bits;

  assign unused_ctrl_bits = ctrl_word[EXP_LSB-1:0];
  assign cfg.en   = ctrl_word[EN_BIT];
  assign cfg.expo = ctrl_word[EXP_LSB +: EXP_W];
  assign limit    = LIM_W'(1) << cfg.expo;
endmodule

// File: rtl/gdb_stab_counter.sv
module gdb_stab_counter #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LIM_W-1:0] limit,
  output logic             done,
  output logic [LIM_W-1:0] count
);
  assign done = step && (count == limit - LIM_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)             count <= '0;
    else if (clear || done) count <= '0;
    else if (step)          count <= count + LIM_W'(1);
  end

  // R8: outside a restart the count never reaches the period.
  assert_cnt_below_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear) |-> (count < limit));
endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
  import gdb_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic RST_LEVEL   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              raw_in,
  output logic              filt_out
);
  logic             raw_s;
  logic             filt_q;
  dbcfg_t           cfg_now;
  dbcfg_t           cfg_q;
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] count;
  logic             cfg_chg;
  logic             differ;
  logic             clear;
  logic             step;
  logic             done;

  gdb_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(RST_LEVEL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(raw_s)
  );

  gdb_period_decode u_dec (
    .ctrl_word(ctrl_word), .cfg(cfg_now), .limit(limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  assign cfg_chg = (cfg_now != cfg_q);
  assign differ  = (raw_s != filt_q);
  assign clear   = cfg_chg || !cfg_now.en || !differ;
  assign step    = ms_tick && !clear;

  gdb_stab_counter #(.LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .limit(limit), .done(done), .count(count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          filt_q <= RST_LEVEL;
    else if (!cfg_now.en) filt_q <= raw_s;
    else if (done)        filt_q <= raw_s;
  end

  assign filt_out = filt_q;

  // R2: in bypass the output copies the synchronised input one edge later.
  assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_now.en) |=> (filt_out == $past(raw_s)));

  // R5: with filtering on, a cycle without a tick leaves the output alone.
  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_now.en && !ms_tick) |=> $stable(filt_out));

  // R4: input equal to the output forces the count back to zero.
  assert_bounce_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_now.en && (raw_s == filt_q)) |=> (count == '0));

  // R6: reprogramming discards the partial count.
  assert_cfg_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (count == '0));

  // R3: a filtered change needs a tick in the cycle before it.
  assert_change_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_now.en && ms_tick && !done) |=> $stable(filt_out));
endmodule

// File: tb/tb_gpio_debounce_filter.sv
module tb_gpio_debounce_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic [8:0] ctrl_word = 9'h000;
  logic       raw_in = 1'b0;
  logic       filt_out;

  int  n_run = 0;
  int  n_fail = 0;
  bit  cur;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  gpio_debounce_filter dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .ctrl_word(ctrl_word), .raw_in(raw_in), .filt_out(filt_out)
  );

  // Table: control word and number of ticks given after a raw toggle.
  localparam int NV = 10;
  localparam logic [8:0] V_CTRL [0:NV-1] = '{
    9'h100, 9'h140, 9'h140, 9'h160, 9'h1A0,
    9'h1E0, 9'h1E0, 9'h0E0, 9'h13F, 9'h120 };
  localparam int V_TICKS [0:NV-1] = '{
    1, 3, 4, 7, 32, 127, 128, 0, 2, 1 };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      cyc(1);
      ms_tick = 1'b0;
      cyc(1);
    end
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: filt_out=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic restore();
    ctrl_word = 9'h000;
    cyc(5);
    cur = raw_in;
  endtask

  task automatic arm(input logic [8:0] c);
    ctrl_word = c;
    cyc(2);
    raw_in = ~cur;
    cyc(4);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset level regardless of the raw pin
    raw_in = 1'b1;
    cyc(3);
    check(filt_out, 1'b0, "R1 during reset");
    raw_in = 1'b0;
    cyc(1);
    rst_n = 1'b1;
    cyc(1);
    check(filt_out, 1'b0, "R1 after reset");
    restore();

    // Table walk: R2 (bypass), R3 (period), R7 (low bits ignored), R9 (limits)
    for (int v = 0; v < NV; v++) begin
      bit en;
      int need;
      bit chg;
      en   = V_CTRL[v][8];
      need = 1 << V_CTRL[v][7:5];
      chg  = !en || (V_TICKS[v] >= need);
      arm(V_CTRL[v]);
      ticks(V_TICKS[v]);
      cyc(2);
      check(filt_out, chg ? ~cur : cur, en ? "R3 R7 R9 table" : "R2 table");
      restore();
    end

    // R2: exact bypass latency of three edges
    raw_in = ~cur;
    cyc(2);
    check(filt_out, cur, "R2 before third edge");
    cyc(1);
    check(filt_out, ~cur, "R2 on third edge");
    restore();

    // R4: bounce back restarts the count
    arm(9'h140);
    ticks(3);
    raw_in = cur;
    cyc(4);
    raw_in = ~cur;
    cyc(4);
    ticks(3);
    check(filt_out, cur, "R4 count restarted after bounce");
    ticks(1);
    check(filt_out, ~cur, "R4 full period after bounce");
    restore();

    // R5: no ticks, no change
    arm(9'h100);
    cyc(50);
    check(filt_out, cur, "R5 no tick no change");
    ticks(1);
    check(filt_out, ~cur, "R5 R9 single tick with n=0");
    restore();

    // R6: exponent change restarts the count
    arm(9'h140);
    ticks(3);
    ctrl_word = 9'h160;
    cyc(2);
    ticks(7);
    check(filt_out, cur, "R6 restart on exponent change");
    ticks(1);
    check(filt_out, ~cur, "R6 new period completes");
    restore();

    // R6: tick in the same cycle as reprogramming is dropped
    arm(9'h120);
    ticks(1);
    ms_tick = 1'b1;
    ctrl_word = 9'h100;
    cyc(1);
    ms_tick = 1'b0;
    cyc(2);
    check(filt_out, cur, "R6 tick coinciding with change ignored");
    ticks(1);
    check(filt_out, ~cur, "R6 next tick counted");
    restore();

    // R7: flipping low bits does not restart the count
    arm(9'h140);
    ticks(3);
    ctrl_word = 9'h15A;
    cyc(2);
    ticks(1);
    check(filt_out, ~cur, "R7 low bits leave count intact");
    restore();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule